// File: doc/BRIEF.md
# Multi-Mode Complex Frequency Translator

This block is the mixing stage of a digital down-converter. Each accepted sample is multiplied by the quadrature words (cosine and sine) of an external numerically controlled oscillator, which moves a chosen channel to DC. The decimating filters that follow must reject the image this creates. A per-beat mode field selects one of three mixing modes. In real mode a single real stream is mixed. In diversity mode two real streams, A and B, arrive interleaved and share one set of oscillator words, so both receive the same phase rotation. In complex mode an I/Q pair goes through a full complex multiply. A bypass flag disables rotation in every mode.

The input and output are valid/ready streams. A beat transfers on a rising clock edge when valid and ready are both high. The source keeps its fields steady until its beat is accepted. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output fields hold still and the input is stalled. The effective sample rate is the clock rate scaled by the fraction of cycles that carry an accepted beat. In diversity mode each channel therefore runs at half the accepted-beat rate.

Operands are 16-bit signed with 15 fractional bits. Results are 18-bit signed. The channel select travels with its sample as a tag.

Top module: `cplx_freq_xlate`

## Requirements
- R1: Mode 0 (real, `in_mode`=0, `in_bypass`=0): `out_i` = floor((x·cos + 2^14) / 2^15) and `out_q` = floor((x·sin + 2^14) / 2^15), where x is `in_i`. Ties therefore round upward: x=1, cos=16384 gives 1, and x=-1, cos=16384 gives 0.
- R2: Mode 1 (diversity, `in_mode`=1): a beat with `in_chan`=0 (channel A) uses the live `nco_cos`/`nco_sin` and stores them. A beat with `in_chan`=1 (channel B) uses the words stored at the most recent accepted A beat and ignores the live words. The arithmetic is as in R1. The words are stored even when bypass is set.
- R3: Mode 2 (complex, `in_mode`=2): `out_i` = floor((i·cos − q·sin + 2^14)/2^15) and `out_q` = floor((i·sin + q·cos + 2^14)/2^15), with i=`in_i` and q=`in_q`.
- R4: When bypass is set in mode 0 or 1, `out_i` is `in_i` sign-extended and `out_q` is 0.
- R5: When bypass is set in mode 2, `out_i` and `out_q` are `in_i` and `in_q` sign-extended.
- R6: An accepted beat appears on the output two clock edges later if the output is not stalled in between. `out_chan` equals that beat's `in_chan`.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_i`, `out_q` and `out_chan` hold their values into the next cycle.
- R8: After reset `out_valid` is 0 and `in_ready` is 1.
- R9: In modes 0 and 1, `in_q` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_chan | input | 1 | Channel select, 0 = A, 1 = B |
| in_mode | input | 2 | 0 real, 1 diversity, 2 complex |
| in_bypass | input | 1 | Pass samples through without rotation |
| in_i | input | 16 | Real sample, or I of a complex sample |
| in_q | input | 16 | Q of a complex sample |
| nco_cos | input | 16 | Oscillator cosine word |
| nco_sin | input | 16 | Oscillator sine word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts output beat |
| out_chan | output | 1 | Channel tag of the output beat |
| out_i | output | 18 | In-phase result |
| out_q | output | 18 | Quadrature result |

## Verification
Two events can land on the same edge. In the first, channel A stores its oscillator words while the channel B beat right behind it must already use them. In the second, a new beat is accepted on the same edge that a stalled output is released. The first case is provoked by back-to-back A/B pairs in which the live words change on every B beat. The second is provoked by random toggling of `out_ready` under a continuous input stream. A scoreboard judges every output beat against arithmetic the bench computes itself, including the stored-word rule. A separate check confirms that the output holds still across each stalled cycle.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    XM_REAL = 2'd0,
    XM_DIV  = 2'd1,
    XM_CPLX = 2'd2
  } xlate_mode_e;
endpackage

// File: rtl/ftx_operand_sel.sv
// Picks the oscillator words for each beat and zeroes the Q operand for real modes.
module ftx_operand_sel
  import ftx_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic [1:0]           mode,
  input  logic                 chan,
  input  logic signed [DW-1:0] raw_q,
  input  logic signed [NW-1:0] live_cos,
  input  logic signed [NW-1:0] live_sin,
  output logic signed [DW-1:0] op_q,
  output logic signed [NW-1:0] op_cos,
  output logic signed [NW-1:0] op_sin
);
  logic signed [NW-1:0] held_cos, held_sin;
  logic is_div, is_cplx, take_held;

  assign is_div    = (mode == XM_DIV);
  assign is_cplx   = (mode == XM_CPLX);
  assign take_held = is_div && chan;

  // Words are captured on every accepted channel A beat in diversity mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      held_cos <= '0;
      held_sin <= '0;
    end else if (accept && is_div && !chan) begin
      held_cos <= live_cos;
      held_sin <= live_sin;
    end
  end

  always_comb begin
    op_cos = take_held ? held_cos : live_cos;
    op_sin = take_held ? held_sin : live_sin;
    op_q   = is_cplx ? raw_q : '0;
  end
endmodule

// File: rtl/ftx_prod_stage.sv
// First pipeline stage: four partial products plus the raw operands for bypass.
module ftx_prod_stage #(
  parameter int DW = 16,
  parameter int NW = 16,
  localparam int PW = DW + NW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 vin,
  input  logic                 chan_in,
  input  logic                 byp_in,
  input  logic signed [DW-1:0] xi,
  input  logic signed [DW-1:0] xq,
  input  logic signed [NW-1:0] c,
  input  logic signed [NW-1:0] s,
  output logic                 vout,
  output logic                 chan_out,
  output logic                 byp_out,
  output logic signed [DW-1:0] xi_out,
  output logic signed [DW-1:0] xq_out,
  output logic signed [PW-1:0] prod [4]
);
  logic signed [DW-1:0] mul_a [4];
  logic signed [NW-1:0] mul_b [4];

  // Product order: i*cos, q*sin, i*sin, q*cos.
  assign mul_a[0] = xi;  assign mul_b[0] = c;
  assign mul_a[1] = xq;  assign mul_b[1] = s;
  assign mul_a[2] = xi;  assign mul_b[2] = s;
  assign mul_a[3] = xq;  assign mul_b[3] = c;

  for (genvar g = 0; g < 4; g++) begin : g_mul
    always_ff @(posedge clk) begin
      if (en) prod[g] <= mul_a[g] * mul_b[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
    end else if (en) begin
      vout <= vin;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      chan_out <= chan_in;
      byp_out  <= byp_in;
      xi_out   <= xi;
      xq_out   <= xq;
    end
  end
endmodule

// File: rtl/ftx_sum_round.sv
// Second pipeline stage: combine the products, round half up, or pass raw values.
module ftx_sum_round #(
  parameter int DW   = 16,
  parameter int NW   = 16,
  parameter int OW   = 18,
  parameter int FRAC = 15,
  localparam int PW = DW + NW,
  localparam int SW = PW + 1,
  localparam int RW = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 vin,
  input  logic                 chan_in,
  input  logic                 byp,
  input  logic signed [DW-1:0] xi,
  input  logic signed [DW-1:0] xq,
  input  logic signed [PW-1:0] prod [4],
  output logic                 vout,
  output logic                 chan_out,
  output logic signed [OW-1:0] res_i,
  output logic signed [OW-1:0] res_q
);
  localparam logic signed [RW-1:0] HALF = {{(RW-1){1'b0}}, 1'b1} << (FRAC - 1);

  logic signed [SW-1:0] sum_i, sum_q;
  logic signed [RW-1:0] acc_i, acc_q, sh_i, sh_q;
  logic signed [OW-1:0] nxt_i, nxt_q;

  always_comb begin
    sum_i = {prod[0][PW-1], prod[0]} - {prod[1][PW-1], prod[1]};
    sum_q = {prod[2][PW-1], prod[2]} + {prod[3][PW-1], prod[3]};
    acc_i = {sum_i[SW-1], sum_i} + HALF;
    acc_q = {sum_q[SW-1], sum_q} + HALF;
    sh_i  = acc_i >>> FRAC;
    sh_q  = acc_q >>> FRAC;
    if (byp) begin
      nxt_i = {{(OW-DW){xi[DW-1]}}, xi};
      nxt_q = {{(OW-DW){xq[DW-1]}}, xq};
    end else begin
      nxt_i = sh_i[OW-1:0];
      nxt_q = sh_q[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout <= 1'b0;
    end else if (en) begin
      vout <= vin;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      chan_out <= chan_in;
      res_i    <= nxt_i;
      res_q    <= nxt_q;
    end
  end
endmodule

// File: rtl/cplx_freq_xlate.sv
module cplx_freq_xlate #(
  parameter int DW   = 16,
  parameter int NW   = 16,
  parameter int OW   = 18,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_chan,
  input  logic [1:0]           in_mode,
  input  logic                 in_bypass,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic signed [NW-1:0] nco_cos,
  input  logic signed [NW-1:0] nco_sin,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_chan,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q
);
  localparam int PW = DW + NW;

  logic advance, accept;
  logic signed [DW-1:0] sel_q;
  logic signed [NW-1:0] sel_cos, sel_sin;
  logic s1_valid, s1_chan, s1_byp;
  logic signed [DW-1:0] s1_xi, s1_xq;
  logic signed [PW-1:0] s1_prod [4];

  // The whole pipeline moves together whenever the output slot is free.
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  ftx_operand_sel #(.DW(DW), .NW(NW)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .mode     (in_mode),
    .chan     (in_chan),
    .raw_q    (in_q),
    .live_cos (nco_cos),
    .live_sin (nco_sin),
    .op_q     (sel_q),
    .op_cos   (sel_cos),
    .op_sin   (sel_sin)
  );

  ftx_prod_stage #(.DW(DW), .NW(NW)) u_prod (
    .clk      (clk),
    .rst      (rst),
    .en       (advance),
    .vin      (in_valid),
    .chan_in  (in_chan),
    .byp_in   (in_bypass),
    .xi       (in_i),
    .xq       (sel_q),
    .c        (sel_cos),
    .s        (sel_sin),
    .vout     (s1_valid),
    .chan_out (s1_chan),
    .byp_out  (s1_byp),
    .xi_out   (s1_xi),
    .xq_out   (s1_xq),
    .prod     (s1_prod)
  );

  ftx_sum_round #(.DW(DW), .NW(NW), .OW(OW), .FRAC(FRAC)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .en       (advance),
    .vin      (s1_valid),
    .chan_in  (s1_chan),
    .byp      (s1_byp),
    .xi       (s1_xi),
    .xq       (s1_xq),
    .prod     (s1_prod),
    .vout     (out_valid),
    .chan_out (out_chan),
    .res_i    (out_i),
    .res_q    (out_q)
  );
endmodule

// File: rtl/cplx_freq_xlate_chk.sv
module cplx_freq_xlate_chk #(
  parameter int DW = 16,
  parameter int OW = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_chan,
  input logic [1:0]           in_mode,
  input logic                 in_bypass,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_chan,
  input logic signed [OW-1:0] out_i,
  input logic signed [OW-1:0] out_q
);
  // R7: a stalled output is held and the input is blocked
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q) && $stable(out_chan)));

  p_stall_block_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R6: two edges from acceptance to output, tag carried along
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 (!out_valid || out_ready) |=> (out_valid && out_chan == $past(in_chan, 2)));

  // R4: real bypass drives Q to zero
  p_bypass_q_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_bypass && in_mode != 2'd2) ##1 (!out_valid || out_ready) |=> (out_q == '0));

  // R5: complex bypass passes both components
  p_bypass_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_bypass && in_mode == 2'd2) ##1 (!out_valid || out_ready)
      |=> (out_i == OW'($past(in_i, 2)) && out_q == OW'($past(in_q, 2))));
endmodule

bind cplx_freq_xlate cplx_freq_xlate_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_chan   (in_chan),
  .in_mode   (in_mode),
  .in_bypass (in_bypass),
  .in_i      (in_i),
  .in_q      (in_q),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_chan  (out_chan),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/cplx_freq_xlate_test.sv
module cplx_freq_xlate_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_chan = 1'b0, in_bypass = 1'b0;
  logic [1:0] in_mode = 2'd0;
  logic signed [15:0] in_i = '0, in_q = '0, nco_cos = '0, nco_sin = '0;
  logic out_ready;
  logic in_ready, out_valid, out_chan;
  logic signed [17:0] out_i, out_q;

  int n_checks = 0, n_fail = 0;
  bit ready_rand = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic signed [17:0] ei;
    logic signed [17:0] eq;
    logic               ch;
    int                 req;
  } exp_t;
  exp_t sb[$];
  int cur_tag = 1;

  logic signed [15:0] m_cos = '0, m_sin = '0;

  always #10 clk = ~clk;

  cplx_freq_xlate uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
    .in_mode(in_mode), .in_bypass(in_bypass), .in_i(in_i), .in_q(in_q),
    .nco_cos(nco_cos), .nco_sin(nco_sin), .out_valid(out_valid), .out_ready(out_ready),
    .out_chan(out_chan), .out_i(out_i), .out_q(out_q)
  );

  function automatic logic signed [17:0] rnd15(longint v);
    longint r;
    r = (v + 64'sd16384) >>> 15;
    return 18'(r);
  endfunction

  task automatic check(bit ok, int req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2 out_ready = ready_rand ? 1'($urandom % 2) : 1'b1;
  end

  // Monitor: compare produced beats, then log accepted beats with their expected result.
  bit stalled = 1'b0;
  logic signed [17:0] st_i, st_q;
  logic st_ch;
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled) begin
        check(out_i == st_i && out_q == st_q && out_chan == st_ch, 7, "stalled output held (R7)",
              out_i, st_i);
      end
      stalled = out_valid && !out_ready;
      st_i = out_i; st_q = out_q; st_ch = out_chan;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, 6, "output beat with nothing pending (R6)", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_i == e.ei, e.req, "out_i", out_i, e.ei);
          check(out_q == e.eq, e.req, "out_q", out_q, e.eq);
          check(out_chan == e.ch, 6, "out_chan tag (R6)", out_chan, e.ch);
        end
      end
      if (in_valid && in_ready) begin
        exp_t e;
        logic signed [15:0] c, s, qe;
        longint si, sq;
        c = nco_cos; s = nco_sin;
        if (in_mode == 2'd1) begin
          if (in_chan) begin c = m_cos; s = m_sin; end
          else begin m_cos = nco_cos; m_sin = nco_sin; end
        end
        qe = (in_mode == 2'd2) ? in_q : 16'sd0;
        if (in_bypass) begin
          e.ei = 18'(in_i);
          e.eq = 18'(qe);
        end else begin
          si = longint'(in_i) * longint'(c) - longint'(qe) * longint'(s);
          sq = longint'(in_i) * longint'(s) + longint'(qe) * longint'(c);
          e.ei = rnd15(si);
          e.eq = rnd15(sq);
        end
        e.ch = in_chan;
        e.req = cur_tag;
        sb.push_back(e);
      end
    end
  end

  task automatic send(logic [1:0] md, logic byp, logic ch, logic signed [15:0] xi,
                      logic signed [15:0] xq, logic signed [15:0] c, logic signed [15:0] s, int tag);
    @(posedge clk);
    #2;
    in_valid = 1'b1; in_mode = md; in_bypass = byp; in_chan = ch;
    in_i = xi; in_q = xq; nco_cos = c; nco_sin = s; cur_tag = tag;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle(int n);
    @(posedge clk);
    #2 in_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  function automatic logic signed [15:0] r16();
    return 16'($urandom);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, 8, "out_valid after reset (R8)", out_valid, 0);
    check(in_ready == 1'b1, 8, "in_ready after reset (R8)", in_ready, 1);

    // R1 rounding corners: ties round upward
    send(2'd0, 1'b0, 1'b0, 16'sd1, 16'sd0, 16'sd16384, -16'sd16384, 1);
    send(2'd0, 1'b0, 1'b0, -16'sd1, 16'sd0, 16'sd16384, 16'sd16384, 1);
    send(2'd0, 1'b0, 1'b0, -16'sd32768, 16'sd0, -16'sd32768, 16'sd32767, 1);
    // R3 extreme complex corner
    send(2'd2, 1'b0, 1'b1, -16'sd32768, 16'sd32767, -16'sd32768, 16'sd32767, 3);
    idle(4);

    // R6 directed latency with free-running sink
    @(posedge clk);
    #2 in_valid = 1'b1; in_mode = 2'd0; in_bypass = 1'b0; in_chan = 1'b1;
    in_i = 16'sd1000; nco_cos = 16'sd32767; nco_sin = 16'sd0; cur_tag = 6;
    @(negedge clk);
    @(posedge clk);
    #2 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, 6, "no output one edge after accept (R6)", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, 6, "output two edges after accept (R6)", out_valid, 1);
    idle(3);

    // R1 random real, in_q randomised to show it is ignored (R9)
    for (int k = 0; k < 40; k++) send(2'd0, 1'b0, 1'($urandom % 2), r16(), r16(), r16(), r16(), 9);
    // R2 diversity A/B pairs, live words differ on B beats
    for (int k = 0; k < 40; k++) begin
      send(2'd1, 1'b0, 1'b0, r16(), r16(), r16(), r16(), 2);
      send(2'd1, 1'b0, 1'b1, r16(), r16(), r16(), r16(), 2);
    end
    // R3 random complex
    for (int k = 0; k < 40; k++) send(2'd2, 1'b0, 1'($urandom % 2), r16(), r16(), r16(), r16(), 3);
    // R4 and R5 bypass
    for (int k = 0; k < 20; k++) send(2'($urandom % 2), 1'b1, 1'($urandom % 2), r16(), r16(), r16(), r16(), 4);
    for (int k = 0; k < 20; k++) send(2'd2, 1'b1, 1'($urandom % 2), r16(), r16(), r16(), r16(), 5);
    // R2 bypassed A still stores its words for the next B
    send(2'd1, 1'b1, 1'b0, r16(), r16(), 16'sd12345, -16'sd2222, 4);
    send(2'd1, 1'b0, 1'b1, 16'sd20000, r16(), r16(), r16(), 2);

    // R7 back-pressure: random sink readiness, all modes mixed
    ready_rand = 1'b1;
    for (int k = 0; k < 200; k++) begin
      logic [1:0] md;
      logic byp;
      md = 2'($urandom % 3);
      byp = ($urandom % 5) == 0;
      send(md, byp, (md == 2'd1) ? 1'(k % 2) : 1'($urandom % 2), r16(), r16(), r16(), r16(),
           byp ? ((md == 2'd2) ? 5 : 4) : ((md == 2'd0) ? 1 : (md == 2'd1) ? 2 : 3));
      if ($urandom % 7 == 0) idle(1);
    end
    idle(1);
    ready_rand = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(sb.size() == 0, 6, "all accepted beats delivered (R6)", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog expired: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule